// File: doc/BRIEF.md
# Parallel Panel Sync and Active-Window Timer

This block times a parallel RGB panel interface. It is clocked by the system clock and advances one position per pixel-clock enable. It drives an active-high horizontal sync (FS1) and an active-high vertical sync (FS2). It also drives a data-valid strobe and the column and row index of each active sample. A lookahead request tells an upstream pixel FIFO that the next pixel slot is active, so the FIFO can present that pixel in time.

Every timing quantity comes from a plain configuration input:

- samples per line and lines per frame;
- FS1 period and width;
- FS2 period and width, both counted in pixel slots and not in lines;
- the horizontal delay and active sample count;
- the vertical delay and active line count.

The delays count from the start of the line and frame, which is also where the syncs assert. They do not count from the end of the sync pulses. A typical panel setup is:

| Setting | Value |
|---|---|
| Samples per line | 525 |
| Active samples | 480, starting 43 slots after FS1 rises |
| FS1 width and period | 41 and 525 |
| Lines per frame | 286 |
| Active lines | 272, starting 12 lines after FS2 rises |
| FS2 width | 5250 slots |
| FS2 period | 150150 slots |

The pixel stream has no back-pressure. The request is purely informative. The timer never stalls, and the upstream FIFO must have the pixel ready whenever the request was high on the slot before. Output data is meant to be launched on the falling edge of the interface clock, so that the panel samples it on the rising edge. That launch register sits outside this block.

Top module: `lcd_sync_gen`

## Requirements
- R1: While `enable` was low at the previous clock edge, `fs1_o`, `fs2_o`, `dvalid_o` and `req_o` are 0, `pix_x_o` and `pix_y_o` are 0, and all position counters are held at zero.
- R2: In the first cycle after `enable` is sampled high, the timer is at line position 0 of line 0. FS1 and FS2 are both high together, provided their widths are non-zero.
- R3: FS1 is high during the first `hs_width` slots of each FS1 period of `hs_period` slots. Its phase counter restarts at every frame start.
- R4: FS2 is high during the first `vs_width` pixel slots of each FS2 period of `vs_period` pixel slots. Its phase counter restarts at every frame start.
- R5: `dvalid_o` is high exactly for line positions from `h_delay` to `h_delay + h_active - 1`, and only on active lines.
- R6: Active lines are line numbers from `v_delay` to `v_delay + v_active - 1` within the frame.
- R7: During `dvalid_o`, `pix_x_o` equals the line position minus `h_delay` and `pix_y_o` equals the line number minus `v_delay`. Both are 0 outside the window.
- R8: `req_o` is high exactly when the next pixel slot will be active. That slot is evaluated with the configuration that will be in force for it.
- R9: Configuration inputs are captured only while disabled or on the pixel slot that ends a frame. A mid-frame change first affects the following frame.
- R10: A cycle with `pix_en` low changes no sync, valid or index output.
- R11: The line position wraps after `line_len` slots, and the line number wraps after `frame_lines` lines. Both syncs re-align to the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low clears the timer |
| pix_en | input | 1 | Pixel-slot enable, one pulse per pixel |
| line_len | input | HW | Pixel slots per line |
| frame_lines | input | VW | Lines per frame |
| hs_period | input | HW | FS1 period in slots |
| hs_width | input | HW | FS1 high time in slots |
| vs_period | input | FW | FS2 period in slots |
| vs_width | input | FW | FS2 high time in slots |
| h_delay | input | HW | Slots from line start to first active sample |
| h_active | input | HW | Active samples per line |
| v_delay | input | VW | Lines from frame start to first active line |
| v_active | input | VW | Active lines per frame |
| fs1_o | output | 1 | Horizontal sync, active high |
| fs2_o | output | 1 | Vertical sync, active high |
| dvalid_o | output | 1 | Active-sample strobe |
| pix_x_o | output | HW | Column index in the active window |
| pix_y_o | output | VW | Row index in the active window |
| req_o | output | 1 | Next slot is active; fetch a pixel |

## Verification
The bench targets the frame boundary. A design that latched configuration at any other moment would shift the window or sync width in the middle of a frame. A design that evaluated the lookahead request with stale settings would show a request without a following valid on the first line of a new setup. An FS1 period different from the line length is used to show whether the sync phase really restarts each frame; a design that let it run on would drift across frames. A window that starts at position 0 and fills the whole line, stalls of the pixel enable, and dropping the enable in mid-frame followed by restarting it check the edge, hold and restart behaviour. Off-by-one errors in any of these would misplace syncs, indices or valid by one slot.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
  localparam int unsigned LCD_HW = 12;
  localparam int unsigned LCD_VW = 11;
  localparam int unsigned LCD_FW = 20;
endpackage

// File: rtl/lcd_shadow_reg.sv
module lcd_shadow_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/lcd_pos_cnt.sv
module lcd_pos_cnt #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [HW-1:0] line_len,
  input  logic [VW-1:0] frame_lines,
  output logic [HW-1:0] h_q,
  output logic [VW-1:0] v_q,
  output logic [HW-1:0] h_nxt,
  output logic [VW-1:0] v_nxt,
  output logic          frame_end
);
  logic line_end;

  always_comb begin
    line_end  = (h_q == line_len - HW'(1));
    frame_end = line_end && (v_q == frame_lines - VW'(1));
    h_nxt     = line_end ? '0 : h_q + HW'(1);
    if (!line_end)      v_nxt = v_q;
    else if (frame_end) v_nxt = '0;
    else                v_nxt = v_q + VW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else if (clr) begin
      h_q <= '0;
      v_q <= '0;
    end else if (step) begin
      h_q <= h_nxt;
      v_q <= v_nxt;
    end
  end

  // R11
  h_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_len == '0) || (h_q < line_len));

  // R11
  h_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !line_end) |=> (h_q == $past(h_q) + HW'(1)));
endmodule

// File: rtl/lcd_pulse_gen.sv
module lcd_pulse_gen #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] period,
  input  logic [W-1:0] width,
  output logic         pulse
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (step)   cnt_q <= (cnt_q >= period - W'(1)) ? '0 : cnt_q + W'(1);
  end

  assign pulse = (cnt_q < width);

  // R3 R4
  period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) || (cnt_q < period));
endmodule

// File: rtl/lcd_window.sv
module lcd_window #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input  logic [HW-1:0] h,
  input  logic [VW-1:0] v,
  input  logic [HW-1:0] h_delay,
  input  logic [HW-1:0] h_active,
  input  logic [VW-1:0] v_delay,
  input  logic [VW-1:0] v_active,
  output logic          active,
  output logic [HW-1:0] x,
  output logic [VW-1:0] y
);
  logic [HW:0] hoff;
  logic [VW:0] voff;
  logic        h_in, v_in;

  always_comb begin
    hoff   = {1'b0, h} - {1'b0, h_delay};
    voff   = {1'b0, v} - {1'b0, v_delay};
    h_in   = !hoff[HW] && (hoff[HW-1:0] < h_active);
    v_in   = !voff[VW] && (voff[VW-1:0] < v_active);
    active = h_in && v_in;
    x      = active ? hoff[HW-1:0] : '0;
    y      = active ? voff[VW-1:0] : '0;
  end

  // R7
  always_comb begin
    win_idx_chk: assert (!active || ((x < h_active) && (y < v_active)));
  end
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int unsigned HW = LCD_HW,
  parameter int unsigned VW = LCD_VW,
  parameter int unsigned FW = LCD_FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          pix_en,
  input  logic [HW-1:0] line_len,
  input  logic [VW-1:0] frame_lines,
  input  logic [HW-1:0] hs_period,
  input  logic [HW-1:0] hs_width,
  input  logic [FW-1:0] vs_period,
  input  logic [FW-1:0] vs_width,
  input  logic [HW-1:0] h_delay,
  input  logic [HW-1:0] h_active,
  input  logic [VW-1:0] v_delay,
  input  logic [VW-1:0] v_active,
  output logic          fs1_o,
  output logic          fs2_o,
  output logic          dvalid_o,
  output logic [HW-1:0] pix_x_o,
  output logic [VW-1:0] pix_y_o,
  output logic          req_o
);
  localparam int unsigned CW = 5*HW + 3*VW + 2*FW;

  logic          run_q;
  logic [CW-1:0] cfg_in, cfg_q, cfg_nx;
  logic          frame_end, shadow_load, cnt_step, pulse_clr;
  logic [HW-1:0] h_q, h_nxt;
  logic [VW-1:0] v_q, v_nxt;

  logic [HW-1:0] s_line, s_hper, s_hwid, s_hdel, s_hact;
  logic [VW-1:0] s_lines, s_vdel, s_vact;
  logic [FW-1:0] s_vper, s_vwid;
  logic [HW-1:0] n_line, n_hper, n_hwid, n_hdel, n_hact;
  logic [VW-1:0] n_lines, n_vdel, n_vact;
  logic [FW-1:0] n_vper, n_vwid;

  logic          hs_pulse, vs_pulse, cur_act, nxt_act;
  logic [HW-1:0] cur_x, nxt_x;
  logic [VW-1:0] cur_y, nxt_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= enable;
  end

  assign cfg_in = {line_len, hs_period, hs_width, h_delay, h_active,
                   frame_lines, v_delay, v_active, vs_period, vs_width};

  assign shadow_load = !run_q || (pix_en && frame_end);
  assign cnt_step    = run_q && pix_en;
  assign pulse_clr   = !run_q || (pix_en && frame_end);

  lcd_shadow_reg #(.W(CW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(shadow_load), .d(cfg_in), .q(cfg_q)
  );

  assign {s_line, s_hper, s_hwid, s_hdel, s_hact,
          s_lines, s_vdel, s_vact, s_vper, s_vwid} = cfg_q;

  // Settings in force for the slot after this one
  assign cfg_nx = frame_end ? cfg_in : cfg_q;
  assign {n_line, n_hper, n_hwid, n_hdel, n_hact,
          n_lines, n_vdel, n_vact, n_vper, n_vwid} = cfg_nx;

  lcd_pos_cnt #(.HW(HW), .VW(VW)) u_pos (
    .clk(clk), .rst_n(rst_n), .clr(!run_q), .step(cnt_step),
    .line_len(s_line), .frame_lines(s_lines),
    .h_q(h_q), .v_q(v_q), .h_nxt(h_nxt), .v_nxt(v_nxt),
    .frame_end(frame_end)
  );

  lcd_pulse_gen #(.W(HW)) u_fs1 (
    .clk(clk), .rst_n(rst_n), .clr(pulse_clr), .step(cnt_step),
    .period(s_hper), .width(s_hwid), .pulse(hs_pulse)
  );

  lcd_pulse_gen #(.W(FW)) u_fs2 (
    .clk(clk), .rst_n(rst_n), .clr(pulse_clr), .step(cnt_step),
    .period(s_vper), .width(s_vwid), .pulse(vs_pulse)
  );

  lcd_window #(.HW(HW), .VW(VW)) u_win_cur (
    .h(h_q), .v(v_q), .h_delay(s_hdel), .h_active(s_hact),
    .v_delay(s_vdel), .v_active(s_vact),
    .active(cur_act), .x(cur_x), .y(cur_y)
  );

  lcd_window #(.HW(HW), .VW(VW)) u_win_nxt (
    .h(h_nxt), .v(v_nxt), .h_delay(n_hdel), .h_active(n_hact),
    .v_delay(n_vdel), .v_active(n_vact),
    .active(nxt_act), .x(nxt_x), .y(nxt_y)
  );

  assign fs1_o    = run_q && hs_pulse;
  assign fs2_o    = run_q && vs_pulse;
  assign dvalid_o = run_q && cur_act;
  assign pix_x_o  = run_q ? cur_x : '0;
  assign pix_y_o  = run_q ? cur_y : '0;
  assign req_o    = run_q && nxt_act;

  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !(fs1_o || fs2_o || dvalid_o || req_o));

  // R2
  start_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !run_q) |=>
      ((fs1_o == ($past(hs_width) != '0)) && (fs2_o == ($past(vs_width) != '0))));

  // R8
  req_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && pix_en && enable) |=> dvalid_o);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && enable && !pix_en) |=>
      $stable({fs1_o, fs2_o, dvalid_o, pix_x_o, pix_y_o}));
endmodule

// File: tb/test_lcd_sync_gen.sv
module test_lcd_sync_gen;
  localparam int HW = 12;
  localparam int VW = 11;
  localparam int FW = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0, enable = 1'b0, pix_en = 1'b0;
  logic [HW-1:0] line_len, hs_period, hs_width, h_delay, h_active;
  logic [VW-1:0] frame_lines, v_delay, v_active;
  logic [FW-1:0] vs_period, vs_width;
  logic          fs1_o, fs2_o, dvalid_o, req_o;
  logic [HW-1:0] pix_x_o;
  logic [VW-1:0] pix_y_o;

  lcd_sync_gen i_lcd_sync_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pix_en(pix_en),
    .line_len(line_len), .frame_lines(frame_lines),
    .hs_period(hs_period), .hs_width(hs_width),
    .vs_period(vs_period), .vs_width(vs_width),
    .h_delay(h_delay), .h_active(h_active),
    .v_delay(v_delay), .v_active(v_active),
    .fs1_o(fs1_o), .fs2_o(fs2_o), .dvalid_o(dvalid_o),
    .pix_x_o(pix_x_o), .pix_y_o(pix_y_o), .req_o(req_o)
  );

  typedef struct {
    int ll, fl, hp, hw, hd, ha, vp, vw, vd, va;
  } mcfg_t;

  int    vectors = 0, fails = 0;
  string ph = "R1";
  bit    checking = 0, done = 0;
  int    pen_mode = 0;
  int    lfsr = 32'h1ACE;

  // reference model state
  int    m_h = 0, m_v = 0, m_hs = 0, m_vs = 0;
  bit    m_run = 0;
  mcfg_t sh;

  function automatic mcfg_t live();
    mcfg_t c;
    c.ll = line_len;  c.fl = frame_lines; c.hp = hs_period; c.hw = hs_width;
    c.hd = h_delay;   c.ha = h_active;    c.vp = vs_period; c.vw = vs_width;
    c.vd = v_delay;   c.va = v_active;
    return c;
  endfunction

  function automatic bit in_win(mcfg_t c, int h, int v);
    return (h >= c.hd) && (h < c.hd + c.ha) && (v >= c.vd) && (v < c.vd + c.va);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_h = 0; m_v = 0; m_hs = 0; m_vs = 0; m_run = 0; sh = live();
    end else begin
      if (!m_run) begin
        m_h = 0; m_v = 0; m_hs = 0; m_vs = 0; sh = live();
      end else if (pix_en) begin
        if (m_h == sh.ll - 1 && m_v == sh.fl - 1) begin
          m_h = 0; m_v = 0; m_hs = 0; m_vs = 0; sh = live();
        end else begin
          if (m_h == sh.ll - 1) begin m_h = 0; m_v = m_v + 1; end
          else m_h = m_h + 1;
          m_hs = (m_hs >= sh.hp - 1) ? 0 : m_hs + 1;
          m_vs = (m_vs >= sh.vw * 0 + sh.vp - 1) ? 0 : m_vs + 1;
        end
      end
      m_run = enable;
    end
  end

  task automatic chk(string req, string name, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) %s: actual %0d expected %0d at %0t", req, ph, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking && !done) begin
      bit    fe, act, nact;
      int    nh, nv;
      mcfg_t nc;
      vectors++;
      act = m_run && in_win(sh, m_h, m_v);
      fe  = (m_h == sh.ll - 1) && (m_v == sh.fl - 1);
      if (m_h == sh.ll - 1) begin nh = 0; nv = fe ? 0 : m_v + 1; end
      else begin nh = m_h + 1; nv = m_v; end
      nc   = fe ? live() : sh;
      nact = m_run && in_win(nc, nh, nv);
      if (!m_run) begin
        chk("R1", "fs1", fs1_o, 0);
        chk("R1", "fs2", fs2_o, 0);
        chk("R1", "dvalid", dvalid_o, 0);
        chk("R1", "req", req_o, 0);
        chk("R1", "x", pix_x_o, 0);
        chk("R1", "y", pix_y_o, 0);
      end else begin
        chk("R3", "fs1", fs1_o, int'(m_hs < sh.hw));
        chk("R4", "fs2", fs2_o, int'(m_vs < sh.vw));
        chk("R5", "dvalid", dvalid_o, int'(act));
        chk("R7", "x", pix_x_o, act ? m_h - sh.hd : 0);
        chk("R7", "y", pix_y_o, act ? m_v - sh.vd : 0);
        chk("R8", "req", req_o, int'(nact));
      end
    end
  end

  task automatic set_cfg(int ll, int fl, int hp, int hw, int vp, int vw,
                         int hd, int ha, int vd, int va);
    line_len = HW'(ll); frame_lines = VW'(fl); hs_period = HW'(hp); hs_width = HW'(hw);
    vs_period = FW'(vp); vs_width = FW'(vw); h_delay = HW'(hd); h_active = HW'(ha);
    v_delay = VW'(vd); v_active = VW'(va);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (pen_mode)
        0:       pix_en = 1'b1;
        1:       pix_en = ~pix_en;
        default: pix_en = lfsr[3] | lfsr[7];
      endcase
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (%s): actual running expected finished", ph);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    set_cfg(20, 8, 20, 3, 160, 40, 5, 10, 2, 4);
    pix_en = 1'b1;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1; checking = 1;
    ph = "R1";
    tick(10);
    // R2: enable and check aligned sync start
    ph = "R2";
    enable = 1'b1;
    tick(1);
    @(negedge clk); #1;
    vectors++;
    if (!(fs1_o && fs2_o && pix_x_o == 0)) begin
      fails++;
      $display("FAIL R2: actual fs1=%0d fs2=%0d expected 1 1", fs1_o, fs2_o);
    end
    ph = "R11";
    tick(3 * 160);
    ph = "R10";
    pen_mode = 1; tick(2 * 320);
    pen_mode = 2; tick(400);
    pen_mode = 0;
    // R9: mid-frame change applies from next frame only
    ph = "R9";
    tick(37);
    set_cfg(16, 10, 16, 2, 100, 32, 3, 12, 1, 8);
    tick(3 * 160 + 80);
    // R6: vertical window deep in frame, full-line window, FS1 period off line length
    ph = "R6";
    set_cfg(12, 9, 7, 2, 50, 15, 0, 12, 4, 3);
    tick(4 * 160);
    pen_mode = 2; tick(300);
    pen_mode = 0;
    ph = "R1";
    enable = 1'b0;
    tick(20);
    ph = "R2";
    enable = 1'b1;
    tick(2 * 108 + 5);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule